// File: doc/BRIEF.md
# Maskable Interrupt Event Collector

This block gathers system status signals and turns selected changes on them into latched interrupt flags. Each source has its own detection rule. A supply-sense line fires on a falling edge. The CAN and LIN failure fields fire on any change of any bit. The temperature-warning and ground-shift flags fire on a crossing in either direction. The three supply-fail flags fire when any one of them clears. A per-source enable bit gates each event before it is latched. A disabled source sets nothing.

The status inputs are asynchronous. Each one passes through a synchroniser chain and then through a change detector. For a short window after reset, detection is suppressed while the chain fills. A watchdog overflow pulse, which is synchronous, is routed by mode. In standby with its enable set it becomes an interrupt flag. In every other case it becomes a one-cycle reset request. An active-low interrupt line is asserted while any flag is set. The host reads the flag word with a read strobe, and that read clears every flag except those set by events in the same cycle.

Top module: `irq_collector`

## Requirements
- R1: After synchronous reset, flags_o is 0, irq_n_o is 1 and reset_req_o is 0. Status inputs that differ from zero during reset set no flag in the cycles after reset is released.
- R2: A 1-to-0 transition on sense_i sets flag bit 3 when irq_en_i[3] is 1. A 0-to-1 transition sets nothing.
- R3: Any change of can_fail_i sets flag bit 5, and any change of lin_fail_i sets flag bit 6, each when its enable bit is 1.
- R4: Either transition of temp_warn_i sets flag bit 1, and either transition of gnd_shift_i sets flag bit 2, each when its enable bit is 1.
- R5: Any bit of supply_fail_i going from 1 to 0 sets flag bit 4 when irq_en_i[4] is 1. Bits going from 0 to 1 set nothing.
- R6: wdog_ovf_i high while standby_i is 1 and irq_en_i[0] is 1 sets flag bit 0 on the next edge and raises no reset request.
- R7: wdog_ovf_i high while standby_i is 0, or while irq_en_i[0] is 0, drives reset_req_o high for exactly one cycle after the edge and sets no flag.
- R8: A source whose enable bit is 0 when its event occurs sets no flag.
- R9: A set flag stays set until a read. irq_n_o is 0 exactly while flags_o is nonzero.
- R10: flags_o shows the flag word during the rd_stb_i cycle. At the following edge all flags clear, except flags set by enabled events in that same cycle.
- R11: A change on an asynchronous input that is applied between edges appears in flags_o after the third rising edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_i | input | 1 | Supply-sense line, falling edge is an event (async) |
| can_fail_i | input | CAN_W | CAN failure status field (async) |
| lin_fail_i | input | LIN_W | LIN failure status field (async) |
| temp_warn_i | input | 1 | Temperature-warning comparator output (async) |
| gnd_shift_i | input | 1 | Ground-shift limit flag (async) |
| supply_fail_i | input | SUP_W | Supply-fail flags, clearing is an event (async) |
| wdog_ovf_i | input | 1 | Watchdog overflow pulse, synchronous |
| standby_i | input | 1 | Standby mode indicator, synchronous |
| irq_en_i | input | 7 | Per-source enable bits, indexed like flags_o |
| rd_stb_i | input | 1 | Read strobe, clears flags at the next edge |
| flags_o | output | 7 | Latched flags: 0 watchdog, 1 temperature, 2 ground shift, 3 sense, 4 supply, 5 CAN, 6 LIN |
| irq_n_o | output | 1 | Active-low interrupt request |
| reset_req_o | output | 1 | One-cycle reset request from watchdog routing |

## Verification
The watchdog and flag assertions assume that wdog_ovf_i, standby_i, irq_en_i and rd_stb_i are synchronous to clk. They also assume that each asynchronous status level is held for at least three cycles, so the detector sees one clean transition. The bench changes every input only on falling clock edges. It holds each status level for at least four cycles before the next change. It sweeps a fixed sequence of transitions under three enable patterns: all on, all off, and all on except the target bit.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC   = 7;
    localparam int FIELD_MAX = 8;

    // flag bit positions (visible to software through flags_o)
    localparam int B_WDOG   = 0;
    localparam int B_TEMP   = 1;
    localparam int B_GND    = 2;
    localparam int B_SENSE  = 3;
    localparam int B_SUPPLY = 4;
    localparam int B_CAN    = 5;
    localparam int B_LIN    = 6;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // detection rule applied by a channel
    typedef enum logic [0:0] {
        DET_FALL   = 1'b0,   // any bit goes 1 -> 0
        DET_CHANGE = 1'b1    // any bit differs from previous sample
    } det_e;

    function automatic logic field_event(
        input det_e                 kind,
        input logic [FIELD_MAX-1:0] old_v,
        input logic [FIELD_MAX-1:0] new_v
    );
        if (kind == DET_FALL) return |(old_v & ~new_v);
        return |(old_v ^ new_v);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_chan.sv
module irq_src_chan
    import irq_pkg::*;
#(
    parameter int   W      = 1,
    parameter int   STAGES = 2,
    parameter det_e KIND   = DET_CHANGE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         armed_i,
    input  logic [W-1:0] raw_i,
    output logic         event_o
);
    logic [W-1:0] synced;
    logic [W-1:0] prev_q;
    logic [FIELD_MAX-1:0] old_x, new_x;

    irq_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_i),
        .q_o (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= synced;
    end

    always_comb begin
        old_x = '0;
        new_x = '0;
        old_x[W-1:0] = prev_q;
        new_x[W-1:0] = synced;
    end

    assign event_o = armed_i & field_event(KIND, old_x, new_x);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t ev_i,
    input  src_vec_t en_i,
    input  logic     rd_i,
    output src_vec_t flags_o
);
    src_vec_t flags_q;
    src_vec_t gated;

    assign gated = ev_i & en_i;

    always_ff @(posedge clk) begin
        if (rst)       flags_q <= '0;
        else if (rd_i) flags_q <= gated;
        else           flags_q <= flags_q | gated;
    end

    assign flags_o = flags_q;

    // R8: a newly set flag needs its enable in the previous cycle
    assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(en_i)) == '0));

    // R9: without a read no flag drops
    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R10: after a read only same-cycle enabled events survive
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> ((flags_o & ~$past(ev_i & en_i)) == '0));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irq_pkg::*;
#(
    parameter int CAN_W       = 2,
    parameter int LIN_W       = 2,
    parameter int SUP_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_i,
    input  logic [CAN_W-1:0] can_fail_i,
    input  logic [LIN_W-1:0] lin_fail_i,
    input  logic             temp_warn_i,
    input  logic             gnd_shift_i,
    input  logic [SUP_W-1:0] supply_fail_i,
    input  logic             wdog_ovf_i,
    input  logic             standby_i,
    input  logic [6:0]       irq_en_i,
    input  logic             rd_stb_i,
    output logic [6:0]       flags_o,
    output logic             irq_n_o,
    output logic             reset_req_o
);
    localparam int PRIME = SYNC_STAGES + 1;
    localparam int CNT_W = $clog2(PRIME + 1);

    logic [CNT_W-1:0] prime_q;
    logic             armed;
    src_vec_t         ev;
    src_vec_t         flags;
    logic             reset_req_q;

    // detection stays off until the synchroniser chain and previous sample hold real data
    always_ff @(posedge clk) begin
        if (rst)         prime_q <= '0;
        else if (!armed) prime_q <= prime_q + 1'b1;
    end
    assign armed = (prime_q == CNT_W'(PRIME));

    irq_src_chan #(.W(1), .STAGES(SYNC_STAGES), .KIND(DET_FALL)) u_sense (
        .clk(clk), .rst(rst), .armed_i(armed), .raw_i(sense_i), .event_o(ev[B_SENSE]));

    irq_src_chan #(.W(CAN_W), .STAGES(SYNC_STAGES), .KIND(DET_CHANGE)) u_can (
        .clk(clk), .rst(rst), .armed_i(armed), .raw_i(can_fail_i), .event_o(ev[B_CAN]));

    irq_src_chan #(.W(LIN_W), .STAGES(SYNC_STAGES), .KIND(DET_CHANGE)) u_lin (
        .clk(clk), .rst(rst), .armed_i(armed), .raw_i(lin_fail_i), .event_o(ev[B_LIN]));

    irq_src_chan #(.W(1), .STAGES(SYNC_STAGES), .KIND(DET_CHANGE)) u_temp (
        .clk(clk), .rst(rst), .armed_i(armed), .raw_i(temp_warn_i), .event_o(ev[B_TEMP]));

    irq_src_chan #(.W(1), .STAGES(SYNC_STAGES), .KIND(DET_CHANGE)) u_gnd (
        .clk(clk), .rst(rst), .armed_i(armed), .raw_i(gnd_shift_i), .event_o(ev[B_GND]));

    irq_src_chan #(.W(SUP_W), .STAGES(SYNC_STAGES), .KIND(DET_FALL)) u_supply (
        .clk(clk), .rst(rst), .armed_i(armed), .raw_i(supply_fail_i), .event_o(ev[B_SUPPLY]));

    // watchdog routing: interrupt only in standby, otherwise a reset request
    assign ev[B_WDOG] = wdog_ovf_i & standby_i;

    always_ff @(posedge clk) begin
        if (rst) reset_req_q <= 1'b0;
        else     reset_req_q <= wdog_ovf_i & ~(standby_i & irq_en_i[B_WDOG]);
    end

    irq_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .en_i    (irq_en_i),
        .rd_i    (rd_stb_i),
        .flags_o (flags)
    );

    assign flags_o     = flags;
    assign irq_n_o     = ~(|flags);
    assign reset_req_o = reset_req_q;

    assert_wdog_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (wdog_ovf_i && standby_i && irq_en_i[B_WDOG]) |=> (flags_o[B_WDOG] && !reset_req_o));

    assert_wdog_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (wdog_ovf_i && !(standby_i && irq_en_i[B_WDOG])) |=> reset_req_o);
endmodule

// File: tb/irq_collector_tb.sv
`timescale 1ns/100ps
module irq_collector_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense = 1'b1;
    logic [1:0] can_f = 2'b01;
    logic [1:0] lin_f = 2'b00;
    logic       temp = 1'b0;
    logic       gnd = 1'b0;
    logic [2:0] sup = 3'b000;
    logic       wdog = 1'b0;
    logic       stby = 1'b0;
    logic [6:0] en = 7'h00;
    logic       rd = 1'b0;
    logic [6:0] flags;
    logic       irq_n;
    logic       rreq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_collector u_dut (
        .clk(clk), .rst(rst), .sense_i(sense), .can_fail_i(can_f), .lin_fail_i(lin_f),
        .temp_warn_i(temp), .gnd_shift_i(gnd), .supply_fail_i(sup), .wdog_ovf_i(wdog),
        .standby_i(stby), .irq_en_i(en), .rd_stb_i(rd), .flags_o(flags),
        .irq_n_o(irq_n), .reset_req_o(rreq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // read the flag word, then confirm it cleared (R10, R9)
    task automatic read_clear(input string tag, input logic [6:0] exp);
        rd = 1'b1;
        chk({tag, " R10 read value"}, flags, exp);
        @(negedge clk);
        rd = 1'b0;
        chk({tag, " R10 cleared"}, flags, 0);
        chk({tag, " R9 irq_n idle"}, irq_n, 1);
    endtask

    // one transition of the sweep; returns the bit it should set (-1 for none)
    task automatic step(input int k, output int bitno, output string tag);
        case (k)
            0:  begin sense = 1'b0;   bitno = 3;  tag = "R2 sense fall"; end
            1:  begin sense = 1'b1;   bitno = -1; tag = "R2 sense rise"; end
            2:  begin can_f = 2'b00;  bitno = 5;  tag = "R3 can 1->0"; end
            3:  begin can_f = 2'b01;  bitno = 5;  tag = "R3 can 0->1"; end
            4:  begin lin_f = 2'b10;  bitno = 6;  tag = "R3 lin 0->2"; end
            5:  begin lin_f = 2'b00;  bitno = 6;  tag = "R3 lin 2->0"; end
            6:  begin temp  = 1'b1;   bitno = 1;  tag = "R4 temp rise"; end
            7:  begin temp  = 1'b0;   bitno = 1;  tag = "R4 temp fall"; end
            8:  begin gnd   = 1'b1;   bitno = 2;  tag = "R4 gnd rise"; end
            9:  begin gnd   = 1'b0;   bitno = 2;  tag = "R4 gnd fall"; end
            10: begin sup   = 3'b101; bitno = -1; tag = "R5 supply set"; end
            11: begin sup   = 3'b100; bitno = 4;  tag = "R5 supply clear one"; end
            default: begin sup = 3'b000; bitno = 4; tag = "R5 supply clear last"; end
        endcase
    endtask

    initial begin
        int    b;
        string t;
        logic [6:0] tgt;
        logic [6:0] exp;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset flags", flags, 0);
        chk("R1 reset irq_n", irq_n, 1);
        chk("R1 reset req", rreq, 0);
        en = 7'h7F;
        repeat (6) @(negedge clk);
        chk("R1 no false event after reset", flags, 0);

        // sweep: three enable patterns x all transitions (R2-R5, R8, R9, R11)
        for (int mode = 0; mode < 3; mode++) begin
            for (int k = 0; k < 13; k++) begin
                step(k, b, t);
                tgt = (b >= 0) ? 7'(1 << b) : 7'h00;
                en  = (mode == 0) ? 7'h7F : (mode == 1) ? 7'h00 : (7'h7F & ~tgt);
                exp = (mode == 0) ? tgt : 7'h00;
                repeat (2) @(negedge clk);
                chk({t, " R11 not before third edge"}, flags, 0);
                @(negedge clk);
                chk((mode == 0) ? {t, " flag"} : {t, " R8 disabled"}, flags, exp);
                chk({t, " R9 irq_n"}, irq_n, (exp != 0) ? 0 : 1);
                repeat (2) @(negedge clk);
                chk({t, " R9 sticky"}, flags, exp);
                read_clear(t, exp);
            end
        end

        // R10: event in the read cycle survives the clear
        en = 7'h7F;
        temp = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 preload temp", flags, 7'h02);
        sense = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 sense pending", flags, 7'h02);
        rd = 1'b1;
        chk("R10 read returns old word", flags, 7'h02);
        @(negedge clk);
        rd = 1'b0;
        chk("R10 same-cycle event kept", flags, 7'h08);
        read_clear("R10 tail", 7'h08);
        sense = 1'b1;
        temp  = 1'b0;
        repeat (4) @(negedge clk);
        read_clear("R4 restore", 7'h02);

        // watchdog routing: exhaustive over standby x enable (R6, R7)
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 2; e++) begin
                stby = s[0];
                en   = {6'h00, e[0]};
                wdog = 1'b1;
                @(negedge clk);
                wdog = 1'b0;
                chk((s == 1 && e == 1) ? "R6 wdog flag" : "R7 wdog no flag",
                    flags, (s == 1 && e == 1) ? 7'h01 : 7'h00);
                chk((s == 1 && e == 1) ? "R6 no reset" : "R7 reset req",
                    rreq, (s == 1 && e == 1) ? 0 : 1);
                @(negedge clk);
                chk("R7 reset req one cycle", rreq, 0);
                read_clear("R6 wdog", (s == 1 && e == 1) ? 7'h01 : 7'h00);
            end
        end
        stby = 1'b0;

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule